// File: doc/BRIEF.md
# Edge-Interval Manchester Byte Receiver

This block takes a Manchester-coded serial line and recovers bytes from it. It does not sample in mid-bit. It measures the time between successive line transitions of either polarity, in ticks of an external microsecond enable. It then sorts each interval into one of three kinds: short (one half-bit), long (one full bit) or out of range. The decoder first hunts for a flag preamble. After that it follows the bit stream by tracking the value of the previous bit, throws away the zero a sender inserts after five ones, and packs bits into bytes with the least significant bit arriving first.

The output is a one-cycle byte strobe carrying eight data bits, plus a one-cycle pulse that reports loss of lock. The line cannot be paused, so the byte output has no back-pressure. The consumer must take every strobe in the cycle it appears; a strobe that is not taken is gone. At the end of a transmission, the closing flag's six ones, a gap or a coding error drops the decoder back to its hunt. Frame length, CRC and radio set-up belong to the logic around this block.

Top module: `edge_manchester_rx`

## Requirements
- R1: While reset is held, and afterwards until a preamble has been found, `byte_valid` and `sync_lost` stay 0.
- R2: An interval is the number of cycles with `us_tick` high, counted from the cycle of one line transition (included) up to the next transition (excluded). Rising and falling transitions are treated the same way, and cycles without a tick add nothing.
- R3: An interval below 80 or above 300 ticks is out of range; both 80 and 300 themselves are in range. An out-of-range interval returns the decoder to the hunt. If the decoder was locked, `sync_lost` pulses high for exactly one cycle.
- R4: Locking takes one long interval, then ten short intervals in a row; a long interval during the run restarts the count from zero. The next in-range transition completes the lock, and the decoder emits 0x7E as the first byte. A run that ends with an out-of-range interval emits nothing and does not pulse `sync_lost`.
- R5: While locked, a long interval (more than 200 ticks) gives a new bit equal to the inverse of the previous bit. An interval of exactly 200 ticks counts as short. The previous bit is taken as 0 right after lock.
- R6: Two short intervals in a row give a new bit equal to the previous bit. A short interval followed by a long one is a coding violation: the decoder returns to the hunt and pulses `sync_lost`.
- R7: The first bit received becomes bit 0 of the byte. Every eighth counted bit makes `byte_valid` high for one cycle, in the cycle after the transition that completed the byte, with the byte on `byte_data`.
- R8: After five 1 bits in a row, the next interval must be long. That interval is a stuffed 0: it is dropped without being counted, and the run of ones restarts. A short interval in that slot makes the decoder return to the hunt and pulse `sync_lost`.
- R9: The interval count stops at 301 ticks, so a transition after an idle of any length is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle enable marking each microsecond |
| line_in | input | 1 | Coded data line, already synchronized to `clk` |
| byte_valid | output | 1 | One-cycle strobe for a recovered byte; the consumer cannot stall it |
| byte_data | output | 8 | Recovered byte, valid while `byte_valid` is high |
| sync_lost | output | 1 | One-cycle pulse when a locked decoder drops back to the hunt |

## Verification
The assertions assume that `line_in` is already synchronous to `clk`. They also assume that in-range intervals span many clock cycles, so that two strobes can never fall in back-to-back cycles and every strobe can be traced to a line transition one cycle earlier. The stimulus moves the line only on the falling clock edge and holds each level for a whole number of tick periods. It runs with a tick in every cycle and, in one pass, with a tick every second cycle, so each interval stays well away from the cycle-level limits the properties rely on.

// File: rtl/emr_pkg.sv
package emr_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam logic [7:0]  FLAG_BYTE = 8'h7E;

  typedef enum logic [1:0] {
    IVL_BAD,
    IVL_SHORT,
    IVL_LONG
  } ivl_kind_e;

  typedef enum logic [2:0] {
    S_HUNT,
    S_COUNT,
    S_ARM,
    S_DATA,
    S_HALF,
    S_STUFF
  } dec_state_e;

  typedef struct packed {
    logic vld;
    logic val;
  } bit_evt_t;
endpackage

// File: rtl/emr_edge_timer.sv
module emr_edge_timer #(
  parameter int unsigned CNT_SAT = 301,
  localparam int unsigned CNT_W  = $clog2(CNT_SAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             line_in,
  output logic             edge_o,
  output logic [CNT_W-1:0] interval_o
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(CNT_SAT);

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;

  assign edge_o     = line_in ^ prev_q;
  assign interval_o = cnt_q;

  // the edge cycle's own tick opens the next interval
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= line_in;
      if (edge_o) begin
        cnt_q <= us_tick ? CNT_W'(1) : '0;
      end else if (us_tick && (cnt_q != SAT_V)) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/emr_ivl_class.sv
module emr_ivl_class
  import emr_pkg::*;
#(
  parameter int unsigned CNT_W     = 9,
  parameter int unsigned MIN_LEN   = 80,
  parameter int unsigned MAX_LEN   = 300,
  parameter int unsigned SPLIT_LEN = 200
) (
  input  logic [CNT_W-1:0] interval_i,
  output ivl_kind_e        kind_o
);
  localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] MAX_V   = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] SPLIT_V = CNT_W'(SPLIT_LEN);

  always_comb begin
    if ((interval_i < MIN_V) || (interval_i > MAX_V)) begin
      kind_o = IVL_BAD;
    end else if (interval_i > SPLIT_V) begin
      kind_o = IVL_LONG;
    end else begin
      kind_o = IVL_SHORT;
    end
  end
endmodule

// File: rtl/emr_bit_engine.sv
module emr_bit_engine
  import emr_pkg::*;
#(
  parameter int unsigned PRE_SHORTS = 10,
  parameter int unsigned STUFF_RUN  = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      edge_i,
  input  ivl_kind_e kind_i,
  output bit_evt_t  bit_o,
  output logic      sync_hit_o,
  output logic      lost_o
);
  localparam int unsigned RUN_W  = $clog2(PRE_SHORTS + 1);
  localparam int unsigned ONES_W = $clog2(STUFF_RUN + 1);
  localparam logic [RUN_W-1:0]  LAST_SHORT = RUN_W'(PRE_SHORTS - 1);
  localparam logic [ONES_W-1:0] LAST_ONE   = ONES_W'(STUFF_RUN - 1);

  dec_state_e        state_q, nstate;
  logic [RUN_W-1:0]  shorts_q, n_shorts;
  logic [ONES_W-1:0] ones_q, n_ones;
  logic              last_q, n_last;
  logic              take, tval;
  logic              is_long, in_frame;

  assign is_long  = (kind_i == IVL_LONG);
  assign in_frame = (state_q == S_DATA) || (state_q == S_HALF) || (state_q == S_STUFF);

  always_comb begin
    nstate     = state_q;
    n_shorts   = shorts_q;
    n_last     = last_q;
    n_ones     = ones_q;
    take       = 1'b0;
    tval       = 1'b0;
    lost_o     = 1'b0;
    sync_hit_o = 1'b0;
    if (edge_i) begin
      if (kind_i == IVL_BAD) begin
        lost_o = in_frame;
        nstate = S_HUNT;
      end else begin
        unique case (state_q)
          S_HUNT: begin
            if (is_long) begin
              nstate   = S_COUNT;
              n_shorts = '0;
            end
          end
          S_COUNT: begin
            if (is_long) begin
              n_shorts = '0;
            end else if (shorts_q == LAST_SHORT) begin
              nstate = S_ARM;
            end else begin
              n_shorts = shorts_q + RUN_W'(1);
            end
          end
          S_ARM: begin
            nstate     = S_DATA;
            sync_hit_o = 1'b1;
            n_last     = 1'b0;
            n_ones     = '0;
          end
          S_DATA: begin
            if (is_long) begin
              take = 1'b1;
              tval = ~last_q;
            end else begin
              nstate = S_HALF;
            end
          end
          S_HALF: begin
            if (is_long) begin
              lost_o = 1'b1;
              nstate = S_HUNT;
            end else begin
              take = 1'b1;
              tval = last_q;
            end
          end
          S_STUFF: begin
            if (is_long) begin
              nstate = S_DATA;
              n_last = 1'b0;
              n_ones = '0;
            end else begin
              lost_o = 1'b1;
              nstate = S_HUNT;
            end
          end
          default: nstate = S_HUNT;
        endcase
      end
    end
    if (take) begin
      nstate = S_DATA;
      n_last = tval;
      if (tval) begin
        if (ones_q == LAST_ONE) begin
          nstate = S_STUFF;
          n_ones = '0;
        end else begin
          n_ones = ones_q + ONES_W'(1);
        end
      end else begin
        n_ones = '0;
      end
    end
  end

  assign bit_o.vld = take;
  assign bit_o.val = tval;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_HUNT;
      shorts_q <= '0;
      ones_q   <= '0;
      last_q   <= 1'b0;
    end else begin
      state_q  <= nstate;
      shorts_q <= n_shorts;
      ones_q   <= n_ones;
      last_q   <= n_last;
    end
  end
endmodule

// File: rtl/emr_byte_pack.sv
module emr_byte_pack
  import emr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  bit_evt_t          bit_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o
);
  localparam int unsigned BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sr_q, sr_next;
  logic [BC_W-1:0]   bc_q;

  // new bit enters at the top, so the first bit drifts down to bit 0
  assign sr_next = {bit_i.val, sr_q[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q         <= '0;
      bc_q         <= '0;
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      if (load_i) begin
        sr_q         <= FLAG_BYTE;
        bc_q         <= '0;
        byte_valid_o <= 1'b1;
        byte_data_o  <= FLAG_BYTE;
      end else if (bit_i.vld) begin
        sr_q <= sr_next;
        if (bc_q == BC_LAST) begin
          bc_q         <= '0;
          byte_valid_o <= 1'b1;
          byte_data_o  <= sr_next;
        end else begin
          bc_q <= bc_q + BC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/edge_manchester_rx.sv
module edge_manchester_rx
  import emr_pkg::*;
#(
  parameter int unsigned MIN_LEN    = 80,
  parameter int unsigned MAX_LEN    = 300,
  parameter int unsigned SPLIT_LEN  = 200,
  parameter int unsigned PRE_SHORTS = 10,
  parameter int unsigned STUFF_RUN  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       line_in,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       sync_lost
);
  localparam int unsigned CNT_SAT = MAX_LEN + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_SAT + 1);

  logic             edge_w;
  logic [CNT_W-1:0] interval_w;
  ivl_kind_e        kind_w;
  bit_evt_t         bit_w;
  logic             sync_hit_w;
  logic             lost_w;

  emr_edge_timer #(.CNT_SAT(CNT_SAT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick   (us_tick),
    .line_in   (line_in),
    .edge_o    (edge_w),
    .interval_o(interval_w)
  );

  emr_ivl_class #(
    .CNT_W    (CNT_W),
    .MIN_LEN  (MIN_LEN),
    .MAX_LEN  (MAX_LEN),
    .SPLIT_LEN(SPLIT_LEN)
  ) u_class (
    .interval_i(interval_w),
    .kind_o    (kind_w)
  );

  emr_bit_engine #(
    .PRE_SHORTS(PRE_SHORTS),
    .STUFF_RUN (STUFF_RUN)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_i    (edge_w),
    .kind_i    (kind_w),
    .bit_o     (bit_w),
    .sync_hit_o(sync_hit_w),
    .lost_o    (lost_w)
  );

  emr_byte_pack u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (sync_hit_w),
    .bit_i       (bit_w),
    .byte_valid_o(byte_valid),
    .byte_data_o (byte_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sync_lost <= 1'b0;
    else        sync_lost <= lost_w;
  end
endmodule

// File: rtl/emr_checker.sv
module emr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       line_in,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       sync_lost
);
  logic fresh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          fresh_q <= 1'b1;
    else if (sync_lost)  fresh_q <= 1'b1;
    else if (byte_valid) fresh_q <= 1'b0;
  end

  // R7
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R3
  lost_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |=> !sync_lost);

  // R3
  lost_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && sync_lost));

  // R2
  byte_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> ($past(line_in) != $past(line_in, 2)));

  // R3
  lost_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> ($past(line_in) != $past(line_in, 2)));

  // R4
  first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && fresh_q) |-> (byte_data == 8'h7E));
endmodule

bind edge_manchester_rx emr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_in   (line_in),
  .byte_valid(byte_valid),
  .byte_data (byte_data),
  .sync_lost (sync_lost)
);

// File: tb/edge_manchester_rx_tb.sv
module edge_manchester_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b1;
  logic       line = 1'b0;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       sync_lost;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int kdiv = 1;
  int divc = 0;

  always #5 clk = ~clk;

  edge_manchester_rx u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick   (us_tick),
    .line_in   (line),
    .byte_valid(byte_valid),
    .byte_data (byte_data),
    .sync_lost (sync_lost)
  );

  // tick generator, changes on the falling edge
  always @(negedge clk) begin
    if (divc + 1 >= kdiv) divc = 0;
    else divc = divc + 1;
    us_tick = (divc == 0);
  end

  // ---------------- behavioural reference model ----------------
  int   m_mode, m_shorts, m_last, m_ones, m_acc, m_bits, m_cnt;
  logic m_prev;
  logic exp_valid = 1'b0;
  logic [7:0] exp_data = 8'h00;
  logic exp_lost = 1'b0;

  task automatic m_push(input int b);
    m_acc  = (m_acc >> 1) | (b << 7);
    m_bits = m_bits + 1;
    m_last = b;
    m_mode = 3;
    if (m_bits == 8) begin
      exp_valid = 1'b1;
      exp_data  = m_acc[7:0];
      m_bits    = 0;
    end
    if (b == 1) begin
      m_ones = m_ones + 1;
      if (m_ones == 5) begin
        m_mode = 5;
        m_ones = 0;
      end
    end else begin
      m_ones = 0;
    end
  endtask

  task automatic m_step(input int iv);
    bit bad, lng;
    bad = (iv < 80) || (iv > 300);
    lng = (iv > 200);
    if (bad) begin
      if (m_mode >= 3) exp_lost = 1'b1;
      m_mode = 0;
    end else begin
      case (m_mode)
        0: if (lng) begin m_mode = 1; m_shorts = 0; end
        1: begin
          if (lng) m_shorts = 0;
          else begin
            m_shorts = m_shorts + 1;
            if (m_shorts == 10) m_mode = 2;
          end
        end
        2: begin
          m_mode = 3; m_last = 0; m_ones = 0; m_acc = 8'h7E; m_bits = 0;
          exp_valid = 1'b1; exp_data = 8'h7E;
        end
        3: if (lng) m_push(1 - m_last); else m_mode = 4;
        4: if (lng) begin exp_lost = 1'b1; m_mode = 0; end else m_push(m_last);
        5: if (lng) begin m_mode = 3; m_last = 0; m_ones = 0; end
           else begin exp_lost = 1'b1; m_mode = 0; end
        default: m_mode = 0;
      endcase
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_mode = 0; m_shorts = 0; m_last = 0; m_ones = 0;
      m_acc = 0; m_bits = 0; m_cnt = 0; m_prev = 1'b0;
      exp_valid = 1'b0; exp_lost = 1'b0;
    end else begin
      exp_valid = 1'b0;
      exp_lost  = 1'b0;
      if (line !== m_prev) begin
        m_step(m_cnt);
        m_cnt = us_tick ? 1 : 0;
      end else if (us_tick && m_cnt < 301) begin
        m_cnt = m_cnt + 1;
      end
      m_prev = line;
    end
  end

  // ---------------- per-cycle comparison and capture ----------------
  logic [7:0] got[$];
  logic [7:0] want[$];
  int lost_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      checks = checks + 1;
      if (byte_valid !== exp_valid || (exp_valid && byte_data !== exp_data)) begin
        fails = fails + 1;
        $display("FAIL R7 cycle %0d: valid/data %b/%h expected %b/%h",
                 cyc, byte_valid, byte_data, exp_valid, exp_data);
      end
      checks = checks + 1;
      if (sync_lost !== exp_lost) begin
        fails = fails + 1;
        $display("FAIL R3 cycle %0d: sync_lost %b expected %b", cyc, sync_lost, exp_lost);
      end
      if (byte_valid) got.push_back(byte_data);
      if (sync_lost) lost_cnt = lost_cnt + 1;
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL R1 watchdog: cycles %0d expected below 190000", cyc);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  int e_last = 0;
  int e_ones = 0;
  int lv = 208;
  int sv = 104;

  task automatic seg(input int n);
    repeat (n * kdiv) @(negedge clk);
    line = ~line;
  endtask

  task automatic send_bit(input int b);
    if (b != e_last) seg(lv);
    else begin seg(sv); seg(sv); end
    e_last = b;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      send_bit(int'(v[i]));
      if (v[i]) e_ones = e_ones + 1;
      else e_ones = 0;
      if (e_ones == 5) begin
        send_bit(0);
        e_ones = 0;
      end
    end
  endtask

  task automatic preamble();
    seg(208); seg(208);
    for (int i = 0; i < 10; i++) seg(104);
    seg(150);
    e_last = 0;
    e_ones = 0;
  endtask

  task automatic check_scn(input string tag, input int want_lost);
    bit ok;
    repeat (4) @(negedge clk);
    checks = checks + 1;
    ok = (got.size() == want.size());
    if (ok) begin
      for (int i = 0; i < want.size(); i++) if (got[i] !== want[i]) ok = 0;
    end
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s bytes: got %p expected %p", tag, got, want);
    end
    checks = checks + 1;
    if (lost_cnt != want_lost) begin
      fails = fails + 1;
      $display("FAIL %s sync_lost count: got %0d expected %0d", tag, lost_cnt, want_lost);
    end
    got.delete();
    want.delete();
    lost_cnt = 0;
  endtask

  // ---------------- scenarios ----------------
  initial begin
    repeat (5) @(negedge clk);
    checks = checks + 1;
    if (byte_valid !== 1'b0 || sync_lost !== 1'b0) begin
      fails = fails + 1;
      $display("FAIL R1 in reset: valid/lost %b/%b expected 0/0", byte_valid, sync_lost);
    end
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    checks = checks + 1;
    if (byte_valid !== 1'b0 || sync_lost !== 1'b0 || got.size() != 0) begin
      fails = fails + 1;
      $display("FAIL R1 after reset: valid/lost %b/%b expected 0/0", byte_valid, sync_lost);
    end

    // R5 R6 R7: plain frame, closed by a short-then-long violation
    preamble();
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h00);
    seg(104); seg(208);
    want = '{8'h7E, 8'hA5, 8'h3C, 8'h00};
    check_scn("R5/R6 frame+violation", 1);

    // R8: stuffed zeros dropped; R3 too-short interval ends it
    preamble();
    send_byte(8'hFF); send_byte(8'h1F); send_byte(8'hF8);
    seg(50);
    want = '{8'h7E, 8'hFF, 8'h1F, 8'hF8};
    check_scn("R8 stuffing", 1);

    // R4: long inside the short run restarts the count
    seg(208); seg(208);
    for (int i = 0; i < 5; i++) seg(104);
    seg(208);
    for (int i = 0; i < 10; i++) seg(104);
    seg(150);
    e_last = 0; e_ones = 0;
    send_byte(8'h81);
    seg(50);
    want = '{8'h7E, 8'h81};
    check_scn("R4 restart", 1);

    // R4: incomplete run then bad interval: nothing, no lost pulse
    seg(208); seg(208);
    for (int i = 0; i < 9; i++) seg(104);
    seg(50);
    check_scn("R4 incomplete", 0);

    // R8: six ones without a stuffed zero
    preamble();
    for (int i = 0; i < 6; i++) send_bit(1);
    want = '{8'h7E};
    check_scn("R8 missing stuff", 1);

    // R3 R5: boundary lengths 300/80 inside range, then 301
    preamble();
    lv = 300; sv = 80;
    send_byte(8'h6B);
    lv = 201; sv = 200;
    send_byte(8'h94);
    lv = 208; sv = 104;
    seg(301);
    want = '{8'h7E, 8'h6B, 8'h94};
    check_scn("R3/R5 boundaries", 1);

    // R3: 79 ticks is out of range
    preamble();
    send_byte(8'h33);
    seg(79);
    want = '{8'h7E, 8'h33};
    check_scn("R3 below minimum", 1);

    // R9: long idle saturates and reads as out of range
    preamble();
    send_byte(8'h42);
    seg(2000);
    want = '{8'h7E, 8'h42};
    check_scn("R9 idle", 1);

    // R2: tick every second cycle, intervals still measured in ticks
    kdiv = 2;
    preamble();
    send_byte(8'h5A); send_byte(8'hC3);
    seg(50);
    want = '{8'h7E, 8'h5A, 8'hC3};
    check_scn("R2 slow tick", 1);
    kdiv = 1;

    // R7: bit order across varied patterns
    preamble();
    send_byte(8'h01); send_byte(8'h80); send_byte(8'h7E);
    seg(50);
    want = '{8'h7E, 8'h01, 8'h80, 8'h7E};
    check_scn("R7 bit order", 1);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule